// File: doc/BRIEF.md
# Toggle-Bit Flash Completion Poller

This block watches a NOR-style embedded flash after an erase or program command has been issued and decides when that operation has finished. A request carries the halfword address to watch and a limit in milliseconds. While the flash array is busy, the status word read back at that address flips one bit on every read. The block repeatedly reads that status word over a simple valid/ready read port and compares the flipping bit between two reads. It also looks at a separate time-limit flag that the flash raises when its own internal timer runs out.

Polling runs in rounds. Each round first makes one read and throws the value away. It then makes two reads that are compared. If neither a settled result nor the flash time-limit flag is seen, the block waits for the next millisecond tick and counts it. When the flash time-limit flag is seen, the block makes one extra pair of reads before it decides between success and failure. An external tick supplies the millisecond time base. Typical limits are 500 ms for a sector erase and 20000 ms for a whole-array erase. For a whole-array erase the caller passes the second unlock address as the watch address.

The result is a one-cycle done pulse that carries a two-bit outcome code and the number of milliseconds that elapsed.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, busy, done and rd_valid are low.
- R2: A request (req_valid high) is taken only while busy is low. A request raised while busy is high does not change the watched address and does not start a second operation.
- R3: Every read of an operation goes to the requested address. A round is one discarded read followed by two compared reads. Each read completes in a cycle where rd_valid and rd_ready are both high, and a low rd_ready only delays it.
- R4: If bit 6 (the toggle bit) is equal in the two compared reads, the operation ends with status 0 (success).
- R5: If bit 6 differs and bit 5 (the flash time-limit flag) is set in the first compared read, two more reads follow. Equal bit 6 in that pair gives status 0. A difference gives status 1 (failure). Either way the operation ends after exactly five reads in that round.
- R6: If bit 6 differs and bit 5 is clear, no read is made until ms_tick is next high. That tick adds one to the elapsed count and a new round starts.
- R7: If a tick raises the elapsed count above the requested limit, the operation ends with status 2 (timeout). elapsed_ms then reports the limit plus one.
- R8: A completed read with rd_err high ends the operation in the next cycle with status 3 (bus error), and no further read is made.
- R9: done is high for exactly one cycle per operation. busy stays high from the cycle after acceptance through the done cycle and is low in the cycle after done. status and elapsed_ms are valid while done is high.
- R10: The value returned by the discarded read has no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request |
| req_addr | input | ADDR_W | Halfword address to poll |
| req_timeout_ms | input | TMO_W | Limit in milliseconds |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| rd_valid | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_ready | input | 1 | Read accepted; rd_data and rd_err valid this cycle |
| rd_data | input | DATA_W | Read data |
| rd_err | input | 1 | Read failed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 success, 1 failure, 2 timeout, 3 bus error |
| elapsed_ms | output | TMO_W+1 | Ticks counted during the operation |

## Verification
A sequencer that lands in the wrong phase changes the number of accepted reads before done. Bad state there shows as a wrong read count or a wrong outcome code, seen at the done pulse of the same operation. A fault in the elapsed counter, or a wrong compare against the limit, shows as a wrong elapsed_ms, or as a timeout one tick early or late. A fault in the captured first read shows up in the round where the toggle bit settles or where bit 5 is first seen. The bench drives a scripted status sequence with ticks spaced eight cycles apart, so every miscount moves done by a whole round.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_FAIL    = 2'd1,
    ST_TIMEOUT = 2'd2,
    ST_BUSERR  = 2'd3
  } tbp_status_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DISCARD,
    PH_FIRST,
    PH_SECOND,
    PH_CONF_A,
    PH_CONF_B,
    PH_WAIT,
    PH_DONE
  } tbp_phase_e;

endpackage

// File: rtl/tbp_eval.sv
module tbp_eval #(
  parameter int DATA_W     = 16,
  parameter int TOGGLE_BIT = 6,
  parameter int LIMIT_BIT  = 5
) (
  input  logic [DATA_W-1:0] first_word,
  input  logic [DATA_W-1:0] second_word,
  output logic              settled,
  output logic              limit_hit
);
  localparam logic [DATA_W-1:0] TOG_MASK = DATA_W'(1) << TOGGLE_BIT;
  localparam logic [DATA_W-1:0] LIM_MASK = DATA_W'(1) << LIMIT_BIT;

  always_comb begin
    settled   = ((first_word ^ second_word) & TOG_MASK) == '0;
    limit_hit = |(first_word & LIM_MASK);
  end
endmodule

// File: rtl/tbp_ms_count.sv
module tbp_ms_count #(
  parameter int TMO_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           inc,
  input  logic [TMO_W-1:0] limit,
  output logic [TMO_W:0] count,
  output logic           exceed_on_inc
);
  localparam int ELW = TMO_W + 1;

  logic [ELW-1:0] cnt_q, cnt_d;
  logic [ELW-1:0] cnt_plus;

  always_comb begin
    cnt_plus      = cnt_q + ELW'(1);
    exceed_on_inc = cnt_plus > {1'b0, limit};
    cnt_d         = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_plus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || inc) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R7: the count never passes the limit by more than one
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ({1'b0, limit} + ELW'(1)));
endmodule

// File: rtl/tbp_seq.sv
module tbp_seq
  import tbp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        rd_ready,
  input  logic        rd_err,
  input  logic        ms_tick,
  input  logic        settled,
  input  logic        limit_hit,
  input  logic        exceed_on_inc,
  output tbp_phase_e  phase,
  output logic        load_req,
  output logic        cap_first,
  output logic        cnt_clr,
  output logic        cnt_inc,
  output tbp_status_e status
);
  tbp_phase_e  ph_q, ph_d;
  tbp_status_e st_q, st_d;
  logic        st_we;
  logic        in_read;

  always_comb begin
    ph_d      = ph_q;
    st_d      = st_q;
    st_we     = 1'b0;
    load_req  = 1'b0;
    cap_first = 1'b0;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    in_read   = (ph_q == PH_DISCARD) || (ph_q == PH_FIRST) || (ph_q == PH_SECOND) ||
                (ph_q == PH_CONF_A)  || (ph_q == PH_CONF_B);
    if (ph_q == PH_IDLE) begin
      if (req_valid) begin
        load_req = 1'b1;
        cnt_clr  = 1'b1;
        ph_d     = PH_DISCARD;
      end
    end else if (in_read) begin
      if (rd_ready) begin
        if (rd_err) begin
          ph_d  = PH_DONE;
          st_d  = ST_BUSERR;
          st_we = 1'b1;
        end else begin
          unique case (ph_q)
            PH_DISCARD: ph_d = PH_FIRST;
            PH_FIRST: begin
              cap_first = 1'b1;
              ph_d      = PH_SECOND;
            end
            PH_SECOND: begin
              if (settled) begin
                ph_d  = PH_DONE;
                st_d  = ST_OK;
                st_we = 1'b1;
              end else if (limit_hit) begin
                ph_d = PH_CONF_A;
              end else begin
                ph_d = PH_WAIT;
              end
            end
            PH_CONF_A: begin
              cap_first = 1'b1;
              ph_d      = PH_CONF_B;
            end
            PH_CONF_B: begin
              ph_d  = PH_DONE;
              st_d  = settled ? ST_OK : ST_FAIL;
              st_we = 1'b1;
            end
            default: ph_d = PH_IDLE;
          endcase
        end
      end
    end else if (ph_q == PH_WAIT) begin
      if (ms_tick) begin
        cnt_inc = 1'b1;
        if (exceed_on_inc) begin
          ph_d  = PH_DONE;
          st_d  = ST_TIMEOUT;
          st_we = 1'b1;
        end else begin
          ph_d = PH_DISCARD;
        end
      end
    end else begin
      ph_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_OK;
    else if (st_we) st_q <= st_d;
  end

  assign phase  = ph_q;
  assign status = st_q;

  // R9: the done phase never lasts two cycles
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DONE) |=> (ph_q == PH_IDLE));

  // R8: a failed read ends the operation with the bus error code
  a_r8_err_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read && rd_ready && rd_err) |=> (ph_q == PH_DONE && st_q == ST_BUSERR));

  // R6: a wait round leaves only on a tick
  a_r6_wait_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WAIT && !ms_tick) |=> (ph_q == PH_WAIT));
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
  import tbp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 16,
  parameter int TMO_W      = 16,
  parameter int TOGGLE_BIT = 6,
  parameter int LIMIT_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TMO_W-1:0]  req_timeout_ms,
  input  logic              ms_tick,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_err,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [TMO_W:0]    elapsed_ms
);
  tbp_phase_e        phase;
  tbp_status_e       st;
  logic              load_req, cap_first, cnt_clr, cnt_inc;
  logic              settled, limit_hit, exceed_on_inc;
  logic [ADDR_W-1:0] addr_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [DATA_W-1:0] first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      tmo_q  <= '0;
    end else if (load_req) begin
      addr_q <= req_addr;
      tmo_q  <= req_timeout_ms;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         first_q <= '0;
    else if (cap_first) first_q <= rd_data;
  end

  tbp_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .rd_ready      (rd_ready),
    .rd_err        (rd_err),
    .ms_tick       (ms_tick),
    .settled       (settled),
    .limit_hit     (limit_hit),
    .exceed_on_inc (exceed_on_inc),
    .phase         (phase),
    .load_req      (load_req),
    .cap_first     (cap_first),
    .cnt_clr       (cnt_clr),
    .cnt_inc       (cnt_inc),
    .status        (st)
  );

  tbp_eval #(
    .DATA_W     (DATA_W),
    .TOGGLE_BIT (TOGGLE_BIT),
    .LIMIT_BIT  (LIMIT_BIT)
  ) u_eval (
    .first_word  (first_q),
    .second_word (rd_data),
    .settled     (settled),
    .limit_hit   (limit_hit)
  );

  tbp_ms_count #(.TMO_W(TMO_W)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (cnt_clr),
    .inc           (cnt_inc),
    .limit         (tmo_q),
    .count         (elapsed_ms),
    .exceed_on_inc (exceed_on_inc)
  );

  always_comb begin
    busy     = (phase != PH_IDLE);
    done     = (phase == PH_DONE);
    rd_valid = (phase == PH_DISCARD) || (phase == PH_FIRST) || (phase == PH_SECOND) ||
               (phase == PH_CONF_A)  || (phase == PH_CONF_B);
    rd_addr  = addr_q;
    status   = st;
  end

  // R2: the watched address holds for the whole operation
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (rd_addr == $past(rd_addr)));

  // R7: a timeout is reported only once the count is above the limit
  a_r7_timeout_above: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd2) |-> (elapsed_ms > {1'b0, tmo_q}));

  // R9: busy drops right after done
  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R4: a settled compared pair ends in success
  a_r4_settle_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SECOND && rd_ready && !rd_err && settled) |=> (done && status == 2'd0));
endmodule

// File: tb/flash_toggle_poller_tb.sv
module flash_toggle_poller_tb_top;
  localparam int AW = 32;
  localparam int DW = 16;
  localparam int TW = 16;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [TW-1:0] req_timeout_ms;
  logic          ms_tick;
  logic          rd_valid;
  logic [AW-1:0] rd_addr;
  logic          rd_ready;
  logic [DW-1:0] rd_data;
  logic          rd_err;
  logic          busy, done;
  logic [1:0]    status;
  logic [TW:0]   elapsed_ms;

  flash_toggle_poller dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_timeout_ms(req_timeout_ms), .ms_tick(ms_tick), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data), .rd_err(rd_err),
    .busy(busy), .done(done), .status(status), .elapsed_ms(elapsed_ms)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [DW-1:0] scr [32];
  logic          scr_err [32];
  int            n_scr = 0;
  int            rd_idx = 0;
  int            done_cnt = 0;
  int            bad_addr = 0;
  int            busy_gap = 0;
  int            dbl_done = 0;
  logic          in_op = 1'b0;
  logic          prev_done = 1'b0;
  logic [1:0]    last_st = '0;
  logic [TW:0]   last_el = '0;
  logic [AW-1:0] exp_addr = '0;
  logic          clr_mon = 1'b0;
  logic          tick_en = 1'b0;
  logic          stall_en = 1'b0;
  logic [2:0]    tick_cnt = '0;

  always_comb begin
    if (rd_idx < n_scr) begin
      rd_data = scr[rd_idx[4:0]];
      rd_err  = scr_err[rd_idx[4:0]];
    end else begin
      rd_data = (rd_idx % 2 == 1) ? 16'h0040 : 16'h0000;
      rd_err  = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    tick_cnt <= tick_cnt + 3'd1;
    ms_tick  <= tick_en && (tick_cnt == 3'd6);
    rd_ready <= stall_en ? ~rd_ready : 1'b1;
    prev_done <= done;
    if (clr_mon) begin
      rd_idx <= 0; done_cnt <= 0; bad_addr <= 0; busy_gap <= 0; dbl_done <= 0;
      in_op  <= 1'b0;
    end else begin
      if (rd_valid && rd_ready) begin
        rd_idx <= rd_idx + 1;
        if (rd_addr !== exp_addr) bad_addr <= bad_addr + 1;
      end
      if (req_valid && !busy) in_op <= 1'b1;
      else if (in_op && prev_done === 1'b0 && busy === 1'b0 && cyc > 0 && done_cnt == 0 && $past(in_op))
        busy_gap <= busy_gap + 1;
      if (done) begin
        done_cnt <= done_cnt + 1;
        last_st  <= status;
        last_el  <= elapsed_ms;
        in_op    <= 1'b0;
      end
      if (done && prev_done) dbl_done <= dbl_done + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_scr(input int n, input logic [DW-1:0] w0, w1, w2, w3, w4, w5,
                         w6, w7, w8, input int err_at);
    logic [DW-1:0] w [9];
    w = '{w0, w1, w2, w3, w4, w5, w6, w7, w8};
    n_scr = n;
    for (int i = 0; i < 32; i++) begin
      scr[i]     = (i < 9) ? w[i] : 16'h0000;
      scr_err[i] = (i == err_at);
    end
  endtask

  task automatic run_op(input logic [AW-1:0] a, input logic [TW-1:0] t);
    int guard;
    @(negedge clk);
    clr_mon = 1'b1;
    @(negedge clk);
    clr_mon  = 1'b0;
    exp_addr = a;
    req_addr = a;
    req_timeout_ms = t;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (done_cnt == 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic t_reset;
    check("R1 busy after reset", busy, 0);
    check("R1 done after reset", done, 0);
    check("R1 rd_valid after reset", rd_valid, 0);
  endtask

  task automatic t_settle_first;
    // R4 R10: discarded read shows bit 6 set, compared pair both clear
    set_scr(3, 16'h0040, 16'h0000, 16'h0000, 0, 0, 0, 0, 0, 0, -1);
    tick_en = 1'b1;
    run_op(32'h0000_8000, 16'd500);
    check("R4 status", last_st, 0);
    check("R10 reads", rd_idx, 3);
    check("R3 addr", bad_addr, 0);
    check("R9 elapsed", last_el, 0);
    check("R9 single done", dbl_done, 0);
  endtask

  task automatic t_confirm_ok;
    // R5: bit 5 set in first compared read, confirm pair settles
    set_scr(5, 16'h0000, 16'h0060, 16'h0020, 16'h0040, 16'h0040, 0, 0, 0, 0, -1);
    run_op(32'h0002_0000, 16'd500);
    check("R5 confirm ok status", last_st, 0);
    check("R5 confirm ok reads", rd_idx, 5);
  endtask

  task automatic t_confirm_fail;
    set_scr(5, 16'h0000, 16'h0060, 16'h0020, 16'h0040, 16'h0000, 0, 0, 0, 0, -1);
    run_op(32'h0004_0000, 16'd500);
    check("R5 confirm fail status", last_st, 1);
    check("R5 confirm fail reads", rd_idx, 5);
  endtask

  task automatic t_wait_rounds;
    // R6: two toggling rounds then a settled one
    set_scr(9, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 16'h0000, 16'h0040,
            16'h0040, 16'h0040, 16'h0040, -1);
    run_op(32'h0000_1550, 16'd500);
    check("R6 status", last_st, 0);
    check("R6 elapsed", last_el, 2);
    check("R6 reads", rd_idx, 9);
  endtask

  task automatic t_timeout(input logic [TW-1:0] t);
    set_scr(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, -1);
    run_op(32'h0000_0AA8, t);
    check("R7 timeout status", last_st, 2);
    check("R7 timeout elapsed", last_el, 32'(t) + 1);
    check("R7 timeout reads", rd_idx, 3 * (int'(t) + 1));
  endtask

  task automatic t_bus_err(input int at);
    set_scr(9, 0, 16'h0040, 0, 0, 0, 0, 0, 0, 0, at);
    run_op(32'h0000_0554, 16'd500);
    check("R8 bus error status", last_st, 3);
    check("R8 reads before abort", rd_idx, at + 1);
    check("R8 elapsed", last_el, 0);
  endtask

  task automatic t_stall;
    stall_en = 1'b1;
    set_scr(3, 16'h0000, 16'h0040, 16'h0040, 0, 0, 0, 0, 0, 0, -1);
    run_op(32'h0000_4000, 16'd500);
    check("R3 stalled status", last_st, 0);
    check("R3 stalled reads", rd_idx, 3);
    check("R3 stalled addr", bad_addr, 0);
    stall_en = 1'b0;
  endtask

  task automatic t_busy_ignore;
    int guard;
    set_scr(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, -1);
    @(negedge clk);
    clr_mon = 1'b1;
    @(negedge clk);
    clr_mon = 1'b0;
    exp_addr = 32'h0006_0000;
    req_addr = 32'h0006_0000;
    req_timeout_ms = 16'd3;
    req_valid = 1'b1;
    @(negedge clk);
    req_addr = 32'h0009_9990;
    req_timeout_ms = 16'd0;
    for (int i = 0; i < 15; i++) @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (done_cnt == 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    for (int i = 0; i < 30; i++) @(negedge clk);
    check("R2 one operation", done_cnt, 1);
    check("R2 address kept", bad_addr, 0);
    check("R2 limit kept", last_el, 4);
    check("R9 busy low after done", busy, 0);
    check("R9 no busy gap", busy_gap, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_timeout_ms = '0;
    for (int i = 0; i < 32; i++) begin
      scr[i] = '0;
      scr_err[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_settle_first;
    t_confirm_ok;
    t_confirm_fail;
    t_wait_rounds;
    t_timeout(16'd2);
    t_timeout(16'd0);
    t_bus_err(1);
    t_bus_err(0);
    t_stall;
    t_busy_ignore;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule